// File: doc/BRIEF.md
# Dual Audio Baud-Rate Generator

This block derives two audio bit clocks from a set of four external audio reference clocks. Generator A serves the 44.1 kHz rate family and generator B the 48 kHz family. Each generator picks one reference through its own select field and divides it by a programmable ratio. The ratio is built from a power-of-four prescaler and an 8-bit multiplier.

All logic runs on one system clock. The external references arrive as one-cycle strobes on `src_tick`, one strobe for each reference edge, already synchronised to the system clock. Each generator has two outputs. The first is a one-cycle pulse, issued each time a full divide period of source strobes completes. The second is a derived clock level, low for the first half of each period and high for the second half. A gated copy of generator B's level leaves the block as `clk_out`.

Software sets up the block through a small write/read register port:
- a 10-bit divider word for each generator;
- a control word that holds both source codes and the clock-out enable.

A new divider word does not cut into the running period. It takes effect from the next period boundary.

Top module: `brg_dual_top`

## Requirements
- R1: After reset, both divider words read 2 (a divide of 6), the control word reads 0, and both pulses and `clk_out` are low.
- R2: Address 0 holds generator A's divider word and address 1 holds generator B's. Each is 10 bits: bits 9:8 are the prescaler exponent p and bits 7:0 are N. Write bits above 9 are ignored, and readback returns them as 0.
- R3: Address 2 is the control word. Bit 31 is the clock-out enable, bits 22:20 are generator A's source code and bits 18:16 are generator B's. Every other bit is ignored on write and reads 0.
- R4: A generator's period is D = (2 << 2p)·(N+1) strobes of its selected source. The D-th strobe of a period sets a one-cycle pulse in the system cycle after the strobe.
- R5: Source codes map to `src_tick` bits as follows: 0 selects bit 0 (reference A), 1 selects bit 1 (reference B), 2 selects bit 3 (reference I) and 4 selects bit 2 (reference C). Codes 3, 5, 6 and 7 select nothing, so that generator neither counts nor pulses.
- R6: A divider word written during a period does not change that period. It sets the length of periods that start after the next pulse. The first period after reset uses D = 6.
- R7: A generator's derived clock is low while fewer than D/2 strobes of the current period have been counted, and high after that.
- R8: `clk_out` equals generator B's derived clock while the enable bit is 1, and is 0 while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 divider A, 1 divider B, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_tick | input | 4 | Reference strobes: bit 0 A, bit 1 B, bit 2 C, bit 3 I |
| gen_a_pulse | output | 1 | Generator A period pulse |
| gen_b_pulse | output | 1 | Generator B period pulse |
| gen_a_clk | output | 1 | Generator A derived clock level |
| gen_b_clk | output | 1 | Generator B derived clock level |
| clk_out | output | 1 | Gated copy of generator B's derived clock |

## Verification
The bench builds the block with its default field widths: a 2-bit prescaler exponent, an 8-bit multiplier and four references. These widths cover the whole ratio range, from the smallest divide of 2 up to the largest of 32768. The bench runs a full 32768-strobe period next to a divide-by-2 generator. It also covers:
- the reset ratio of 6;
- each prescaler step;
- every valid source code and two codes that select nothing;
- a divider rewrite that lands in the middle of a period.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Divider word layout: prescaler exponent above an 8-bit multiplier.
    localparam int PRE_W      = 2;
    localparam int MUL_W      = 8;
    localparam int DIV_W      = PRE_W + MUL_W;
    localparam int NUM_SRC    = 4;
    localparam int SRC_IDX_W  = $clog2(NUM_SRC);
    localparam int SRC_CODE_W = 3;
    localparam int NUM_GEN    = 2;
    localparam int GEN_A      = 0;
    localparam int GEN_B      = 1;

    // Largest ratio is 2^(1 + 2*(2^PRE_W - 1)) * 2^MUL_W; one extra bit holds it.
    localparam int RATIO_W    = 2 + 2 * ((1 << PRE_W) - 1) + MUL_W;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam logic [ADDR_W-1:0] ADR_DIV_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTL   = 2'd2;

    localparam int CTL_EN_BIT    = 31;
    localparam int CTL_SRC_A_LSB = 20;
    localparam int CTL_SRC_B_LSB = 16;

    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(2);

    // Reference strobe positions on the source bus.
    localparam logic [SRC_IDX_W-1:0] IN_A = 2'd0;
    localparam logic [SRC_IDX_W-1:0] IN_B = 2'd1;
    localparam logic [SRC_IDX_W-1:0] IN_C = 2'd2;
    localparam logic [SRC_IDX_W-1:0] IN_I = 2'd3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [MUL_W-1:0] mul;
    } div_word_t;

    typedef struct packed {
        logic                  out_en;
        logic [SRC_CODE_W-1:0] src_a;
        logic [SRC_CODE_W-1:0] src_b;
    } ctl_t;

    typedef enum logic [SRC_CODE_W-1:0] {
        CODE_REF_A = 3'd0,
        CODE_REF_B = 3'd1,
        CODE_REF_I = 3'd2,
        CODE_REF_C = 3'd4
    } src_code_e;

    typedef struct packed {
        logic                 valid;
        logic [SRC_IDX_W-1:0] idx;
    } src_route_t;

    // Non-sequential code map; unlisted codes route nowhere.
    function automatic src_route_t src_decode(input logic [SRC_CODE_W-1:0] code);
        src_route_t r;
        r = '0;
        case (code)
            CODE_REF_A: begin r.valid = 1'b1; r.idx = IN_A; end
            CODE_REF_B: begin r.valid = 1'b1; r.idx = IN_B; end
            CODE_REF_I: begin r.valid = 1'b1; r.idx = IN_I; end
            CODE_REF_C: begin r.valid = 1'b1; r.idx = IN_C; end
            default:    r = '0;
        endcase
        return r;
    endfunction

    // Total divide: (2 << 2p) * (N + 1).
    function automatic logic [RATIO_W-1:0] div_ratio(input div_word_t w);
        logic [RATIO_W-1:0] pre_ratio;
        logic [RATIO_W-1:0] mul_ratio;
        pre_ratio = RATIO_W'(2) << {w.pre, 1'b0};
        mul_ratio = RATIO_W'(w.mul) + RATIO_W'(1);
        return pre_ratio * mul_ratio;
    endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output div_word_t [NUM_GEN-1:0]  div_o,
    output ctl_t                     ctl_o
);

    div_word_t [NUM_GEN-1:0] div_q;
    ctl_t                    ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                div_q[g] <= div_word_t'(DIV_RST);
            end
            ctl_q <= '0;
        end else if (we) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (addr == ADDR_W'(g)) begin
                    div_q[g] <= div_word_t'(wdata[DIV_W-1:0]);
                end
            end
            if (addr == ADR_CTL) begin
                ctl_q.out_en <= wdata[CTL_EN_BIT];
                ctl_q.src_a  <= wdata[CTL_SRC_A_LSB +: SRC_CODE_W];
                ctl_q.src_b  <= wdata[CTL_SRC_B_LSB +: SRC_CODE_W];
            end
        end
    end

    // Bits outside the stored fields are dropped on purpose.
    logic unused_wbits;
    assign unused_wbits = ^{wdata[REG_W-2:CTL_SRC_A_LSB+SRC_CODE_W],
                            wdata[CTL_SRC_A_LSB-1:CTL_SRC_B_LSB+SRC_CODE_W],
                            wdata[CTL_SRC_B_LSB-1:DIV_W]};

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_DIV_A: rdata[DIV_W-1:0] = div_q[GEN_A];
            ADR_DIV_B: rdata[DIV_W-1:0] = div_q[GEN_B];
            ADR_CTL: begin
                rdata[CTL_EN_BIT]                   = ctl_q.out_en;
                rdata[CTL_SRC_A_LSB +: SRC_CODE_W]  = ctl_q.src_a;
                rdata[CTL_SRC_B_LSB +: SRC_CODE_W]  = ctl_q.src_b;
            end
            default: rdata = '0;
        endcase
    end

    assign div_o = div_q;
    assign ctl_o = ctl_q;

endmodule

// File: rtl/brg_src_mux.sv
module brg_src_mux
    import brg_pkg::*;
(
    input  logic [NUM_SRC-1:0]    tick_i,
    input  logic [SRC_CODE_W-1:0] code_i,
    output logic                  sel_tick_o
);

    src_route_t route;

    always_comb begin
        route      = src_decode(code_i);
        sel_tick_o = route.valid & tick_i[route.idx];
    end

endmodule

// File: rtl/brg_divider.sv
module brg_divider
    import brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  div_word_t          div_i,
    output logic               pulse_o,
    output logic               level_o,
    output logic [RATIO_W-1:0] cnt_o,
    output logic [RATIO_W-1:0] act_o
);

    localparam logic [RATIO_W-1:0] RST_RATIO = div_ratio(div_word_t'(DIV_RST));

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic               pulse_q;
    logic               last_tick;

    assign last_tick = (cnt_q == act_q - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            act_q   <= RST_RATIO;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick_i) begin
                if (last_tick) begin
                    cnt_q   <= '0;
                    act_q   <= div_ratio(div_i);
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + RATIO_W'(1);
                end
            end
        end
    end

    assign level_o = (cnt_q >= (act_q >> 1));
    assign pulse_o = pulse_q;
    assign cnt_o   = cnt_q;
    assign act_o   = act_q;

endmodule

// File: rtl/brg_dual_top.sv
module brg_dual_top
    import brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               gen_a_pulse,
    output logic               gen_b_pulse,
    output logic               gen_a_clk,
    output logic               gen_b_clk,
    output logic               clk_out
);

    div_word_t [NUM_GEN-1:0]               div_w;
    ctl_t                                  ctl;
    logic [NUM_GEN-1:0][SRC_CODE_W-1:0]    code_v;
    logic [NUM_GEN-1:0]                    sel_tick;
    logic [NUM_GEN-1:0]                    pulse_v;
    logic [NUM_GEN-1:0]                    level_v;
    logic [NUM_GEN-1:0][RATIO_W-1:0]       cnt_v;
    logic [NUM_GEN-1:0][RATIO_W-1:0]       act_v;

    brg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .div_o (div_w),
        .ctl_o (ctl)
    );

    assign code_v[GEN_A] = ctl.src_a;
    assign code_v[GEN_B] = ctl.src_b;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        brg_src_mux u_mux (
            .tick_i     (src_tick),
            .code_i     (code_v[g]),
            .sel_tick_o (sel_tick[g])
        );

        brg_divider u_div (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (sel_tick[g]),
            .div_i   (div_w[g]),
            .pulse_o (pulse_v[g]),
            .level_o (level_v[g]),
            .cnt_o   (cnt_v[g]),
            .act_o   (act_v[g])
        );
    end

    assign gen_a_pulse = pulse_v[GEN_A];
    assign gen_b_pulse = pulse_v[GEN_B];
    assign gen_a_clk   = level_v[GEN_A];
    assign gen_b_clk   = level_v[GEN_B];
    assign clk_out     = ctl.out_en & level_v[GEN_B];

endmodule

// File: rtl/brg_dual_chk.sv
module brg_dual_chk
    import brg_pkg::*;
(
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_GEN-1:0]                sel_tick,
    input logic [NUM_GEN-1:0]                pulse_v,
    input logic [NUM_GEN-1:0]                level_v,
    input logic [NUM_GEN-1:0][RATIO_W-1:0]   cnt_v,
    input logic [NUM_GEN-1:0][RATIO_W-1:0]   act_v
);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        // R4: counter never reaches the active ratio
        assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
            cnt_v[g] < act_v[g]);

        // R4: a pulse lasts exactly one cycle
        assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
            pulse_v[g] |=> !pulse_v[g]);

        // R4: a pulse follows a selected strobe
        assert_pulse_from_tick_R4: assert property (@(posedge clk) disable iff (rst)
            pulse_v[g] |-> $past(sel_tick[g]));

        // R6: active ratio only changes at a period boundary
        assert_ratio_held_R6: assert property (@(posedge clk) disable iff (rst)
            !pulse_v[g] |-> $stable(act_v[g]));

        // R7: derived clock only falls when a new period starts
        assert_level_fall_wrap_R7: assert property (@(posedge clk) disable iff (rst)
            $fell(level_v[g]) |-> pulse_v[g]);
    end

    // R1: no pulse in the first cycle out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pulse_v == '0));

endmodule

bind brg_dual_top brg_dual_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_tick (sel_tick),
    .pulse_v  (pulse_v),
    .level_v  (level_v),
    .cnt_v    (cnt_v),
    .act_v    (act_v)
);

// File: tb/tb_brg_dual_top.sv
module tb_brg_dual_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_tick = '0;
    logic        gen_a_pulse, gen_b_pulse, gen_a_clk, gen_b_clk, clk_out;

    always #2.5 clk = ~clk;

    brg_dual_top dut (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .src_tick    (src_tick),
        .gen_a_pulse (gen_a_pulse),
        .gen_b_pulse (gen_b_pulse),
        .gen_a_clk   (gen_a_clk),
        .gen_b_clk   (gen_b_clk),
        .clk_out     (clk_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Reference model state, driven by the requirements.
    int mdl_cnt [2];
    int mdl_act [2];
    int mdl_pend[2];
    int mdl_src [2];
    bit mdl_en;
    int seen    [2];
    int exp_a[$];
    int exp_b[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input int word);
        int p, n;
        p = (word >> 8) & 3;
        n = word & 255;
        return (2 << (2 * p)) * (n + 1);
    endfunction

    function automatic int route_of(input int code);
        case (code)
            0: return 0;
            1: return 1;
            2: return 3;
            4: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a < 2) mdl_pend[a] = ratio_of(int'(d & 32'h3FF));
        if (a == 2) begin
            mdl_en     = d[31];
            mdl_src[0] = route_of(int'(d[22:20]));
            mdl_src[1] = route_of(int'(d[18:16]));
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, "register readback", reg_rdata, exp);
    endtask

    // Driver: strobes the references and pushes expected pulse cycles.
    task automatic run(input logic [3:0] mask, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = mask;
            @(posedge clk); #1;
            src_tick = '0;
            for (int g = 0; g < 2; g++) begin
                if (mdl_src[g] >= 0 && mask[mdl_src[g]]) begin
                    if (mdl_cnt[g] == mdl_act[g] - 1) begin
                        mdl_cnt[g] = 0;
                        mdl_act[g] = mdl_pend[g];
                        if (g == 0) exp_a.push_back(cyc); else exp_b.push_back(cyc);
                    end else begin
                        mdl_cnt[g]++;
                    end
                end
            end
            repeat (gap) @(posedge clk);
        end
    endtask

    // Monitor: pops expected pulses and compares levels.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            int e;
            bit la, lb;
            if (gen_a_pulse) begin
                seen[0]++;
                if (exp_a.size() == 0) check(1'b0, "R4 R5", "unexpected pulse A at cycle", cyc, -1);
                else begin e = exp_a.pop_front(); check(e == cyc, "R4", "pulse A cycle", cyc, e); end
            end else if (exp_a.size() > 0 && exp_a[0] <= cyc) begin
                e = exp_a.pop_front();
                check(1'b0, "R4 R5", "missing pulse A", cyc, e);
            end
            if (gen_b_pulse) begin
                seen[1]++;
                if (exp_b.size() == 0) check(1'b0, "R4 R5", "unexpected pulse B at cycle", cyc, -1);
                else begin e = exp_b.pop_front(); check(e == cyc, "R4", "pulse B cycle", cyc, e); end
            end else if (exp_b.size() > 0 && exp_b[0] <= cyc) begin
                e = exp_b.pop_front();
                check(1'b0, "R4 R5", "missing pulse B", cyc, e);
            end
            la = (mdl_cnt[0] >= mdl_act[0] / 2);
            lb = (mdl_cnt[1] >= mdl_act[1] / 2);
            check(gen_a_clk == la, "R7", "derived clock A", gen_a_clk, la);
            check(gen_b_clk == lb, "R7", "derived clock B", gen_b_clk, lb);
            check(clk_out == (mdl_en && lb), "R8", "clk_out", clk_out, mdl_en && lb);
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int sa, sb;
        for (int g = 0; g < 2; g++) begin
            mdl_cnt[g] = 0; mdl_act[g] = 6; mdl_pend[g] = 6; mdl_src[g] = 0; seen[g] = 0;
        end
        mdl_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check(gen_a_pulse == 1'b0, "R1", "pulse A after reset", gen_a_pulse, 0);
        check(gen_b_pulse == 1'b0, "R1", "pulse B after reset", gen_b_pulse, 0);
        check(clk_out == 1'b0, "R1", "clk_out after reset", clk_out, 0);
        rd(2'd0, 32'h2, "R1");
        rd(2'd1, 32'h2, "R1");
        rd(2'd2, 32'h0, "R1");
        mon_on = 1'b1;

        // R2: upper write bits dropped
        wr(2'd0, 32'hFFFF_FC05);
        rd(2'd0, 32'h0000_0005, "R2");
        rd(2'd1, 32'h0000_0002, "R2");

        // R6: first period keeps divide 6, later ones use 12 on A
        run(4'b0001, 30, 1);
        check(seen[0] == 3, "R6", "pulses on A with mid-period rewrite", seen[0], 3);
        check(seen[1] == 5, "R6", "pulses on B at reset ratio", seen[1], 5);

        // R3: control field masking
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h8077_0000, "R3");
        wr(2'd2, 32'h8001_0000);
        rd(2'd2, 32'h8001_0000, "R3");

        // R4: A at divide 12 on ref A, B at divide 24 on ref B
        wr(2'd1, 32'h0000_0102);
        run(4'b0011, 50, 0);

        // R5: code 2 -> ref I (bit 3), code 4 -> ref C (bit 2)
        wr(2'd0, 32'h0000_0200);
        wr(2'd1, 32'h0000_0301);
        wr(2'd2, 32'h8024_0000);
        run(4'b1000, 100, 0);
        run(4'b0100, 600, 0);
        run(4'b1100, 300, 0);

        // R5: codes 3 and 7 select nothing
        wr(2'd2, 32'h8037_0000);
        sa = seen[0]; sb = seen[1];
        run(4'b1111, 40, 0);
        repeat (3) @(negedge clk);
        check(seen[0] == sa, "R5", "pulses A with unmapped code", seen[0] - sa, 0);
        check(seen[1] == sb, "R5", "pulses B with unmapped code", seen[1] - sb, 0);

        // R8: clock-out disabled
        wr(2'd2, 32'h0024_0000);
        run(4'b1100, 300, 0);

        // R4: largest divide on A, smallest on B
        wr(2'd0, 32'h0000_03FF);
        wr(2'd1, 32'h0000_0000);
        wr(2'd2, 32'h8001_0000);
        run(4'b0011, 66000, 0);

        repeat (4) @(negedge clk);
        check(exp_a.size() == 0, "R4", "outstanding pulses A", exp_a.size(), 0);
        check(exp_b.size() == 0, "R4", "outstanding pulses B", exp_b.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule